// File: doc/BRIEF.md
# Timeslot DMA Request Controller

This block paces DMA traffic between a time-division serial frame and an external memory engine. A frame is a fixed number of 2 Mb/s slots. Each slot carries exactly four 8-bit lanes, and a per-channel enable vector marks which lanes take part in DMA. One enable bit covers both directions of its channel, so no channel can move in one direction only. A global enable arms the controller. It is only sampled at frame starts, so traffic always begins on a frame boundary.

For every slot that holds at least one enabled lane, a read engine lowers its active-low request when the slot opens. A write engine lowers its own request when the slot closes, which is the moment the next slot opens. After the external engine answers with an active-low acknowledge, the engine moves all enabled lanes of that slot in one burst, lowest lane first. The burst uses valid/ready beats: `rd_valid`/`rd_ready` for bytes leaving the frame and `wr_valid`/`wr_ready` for bytes entering it. Either side may hold back. A beat moves only in a cycle where both are high. The request stays low until the last beat has moved. A slot that is not finished when the next slot opens is abandoned and flagged.

Write data is staggered per serial stream. A byte delivered while a channel is served is parked. It is stored into the next enabled channel that the write side serves on the same stream, and the store port reports that channel.

Top module: `dma_slot_ctrl`

## Requirements
- R1: Slot timing runs freely from reset. A slot lasts SLOT_CYCLES clocks and a frame lasts SLOTS slots. Clock edge k after reset release belongs to cycle k mod SLOT_CYCLES of slot (k / SLOT_CYCLES) mod SLOTS. Lane l of slot s has enable bit `chan_en[4*s+l]`.
- R2: `dma_en` is sampled only at the edge that opens slot 0. While the controller is disarmed, no request goes low. Out of reset, both requests are high, and `rd_valid`, `wr_ready`, `st_valid` and both miss flags are low.
- R3: If slot s has any enabled lane and the controller was armed before the edge that opens s, `rd_req_n` is low from cycle 1 of slot s. A slot with no enabled lane raises no read request.
- R4: The write request for such a slot s goes low from cycle 1 of slot s+1 (modulo SLOTS), using the same enable bits.
- R5: While a request waits, an acknowledge sampled low starts the burst in the next cycle, and acknowledge is ignored at any other time. The burst presents one beat per enabled lane in ascending lane order. The beat advances when its handshake completes. The request returns high in the cycle after the last beat moves. A presented read beat stays valid until taken, unless the slot ends first.
- R6: A beat's stream and channel follow from `mode` and lane l of slot s. In mode 0 (or 3), four streams at 2 Mb/s give stream l, channel s. In mode 1, two streams at 4 Mb/s give stream l/2, channel 2s+(l mod 2). In mode 2, one stream at 8 Mb/s gives stream 0, channel 4s+l.
- R7: `wr_ready` is high exactly while the write burst presents a beat. A write byte is taken in a cycle where `wr_valid` and `wr_ready` are both high.
- R8: One cycle after a write byte is taken for stream k, channel c, `st_valid` is high if an earlier byte was taken on stream k. `st_stream`=k, `st_chan`=c, and `st_data` is that earlier byte. The new byte is then parked for stream k, across slots and frames.
- R9: If a request has not completed its burst by the edge that opens the next slot, its lanes are dropped and the matching miss flag is high for the following cycle. A beat that moves at that edge still counts. The next slot's request may follow without a high gap.
- R10: Slot 0 is served one slot later than the others in the frame where arming takes effect. It gets no request in that frame and is first served in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Global arm, sampled at frame start |
| mode | input | 2 | Lane to stream mapping: 0/3 = 2 Mb/s, 1 = 4 Mb/s, 2 = 8 Mb/s |
| chan_en | input | SLOTS*4 | Per-channel DMA enable, bit 4*slot+lane |
| rd_req_n | output | 1 | Read (frame to memory) request, active low |
| rd_ack_n | input | 1 | Read acknowledge, active low |
| rd_valid | output | 1 | Read beat presented |
| rd_ready | input | 1 | Memory side accepts read beat |
| rd_stream | output | 2 | Stream of the presented read beat |
| rd_chan | output | log2(SLOTS)+2 | Channel of the presented read beat |
| wr_req_n | output | 1 | Write (memory to frame) request, active low |
| wr_ack_n | input | 1 | Write acknowledge, active low |
| wr_valid | input | 1 | Memory side presents a write byte |
| wr_ready | output | 1 | Block accepts a write byte |
| wr_data | input | 8 | Write byte |
| st_valid | output | 1 | Staggered store strobe |
| st_stream | output | 2 | Stream of the store |
| st_chan | output | log2(SLOTS)+2 | Channel receiving the store |
| st_data | output | 8 | Byte to store |
| rd_miss | output | 1 | Read slot abandoned (one-cycle pulse) |
| wr_miss | output | 1 | Write slot abandoned (one-cycle pulse) |

## Verification
A behavioural model runs beside the design and every output is compared on each clock. In the first traffic pattern, 2 Mb/s mapping with acknowledges and handshakes granted at once, exact request edges, lane order and the slot-0 lag are visible with no stall noise. A second pattern uses 4 Mb/s mapping with pseudo-random ready, valid and acknowledge timing. It separates correct back-pressure holding and beat advance from designs that advance on presentation alone. A third pattern uses 8 Mb/s mapping with write acknowledges withheld for a frame, which forces abandoned slots and shows that staggered stores still chain across the gap. Arming and disarming around these patterns show that the enable takes effect only at frame starts.

// File: rtl/dma_slot_pkg.sv
package dma_slot_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 2;
  localparam int STREAMS = 4;
  localparam int STRM_W  = 2;

  typedef enum logic [1:0] {
    RATE_2M = 2'd0,
    RATE_4M = 2'd1,
    RATE_8M = 2'd2
  } slot_rate_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_WAIT  = 2'd1,
    ENG_BURST = 2'd2
  } eng_state_e;
endpackage

// File: rtl/dma_slot_timer.sv
module dma_slot_timer #(
  parameter int SLOTS       = 32,
  parameter int SLOT_CYCLES = 16,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int CYC_W      = $clog2(SLOT_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_req,
  output logic              slot_tick,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [SLOT_W-1:0] prev_slot,
  output logic              rd_live,
  output logic              wr_live
);
  logic [CYC_W-1:0]  cyc_q;
  logic [SLOT_W-1:0] slot_q;
  logic              armed_q;
  logic              prev_live_q;
  logic              last_cyc;
  logic              frame_tick;

  assign slot_tick  = (cyc_q == '0);
  assign frame_tick = slot_tick && (slot_q == '0);
  assign last_cyc   = (cyc_q == CYC_W'(SLOT_CYCLES - 1));
  assign cur_slot   = slot_q;
  assign prev_slot  = (slot_q == '0) ? SLOT_W'(SLOTS - 1) : slot_q - 1'b1;
  // Decisions at a slot edge use the arm state from before that edge,
  // which is what delays slot 0 by one frame after arming.
  assign rd_live    = armed_q;
  assign wr_live    = prev_live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q       <= '0;
      slot_q      <= '0;
      armed_q     <= 1'b0;
      prev_live_q <= 1'b0;
    end else begin
      cyc_q <= last_cyc ? '0 : cyc_q + 1'b1;
      if (last_cyc) begin
        slot_q <= (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
      end
      if (slot_tick) begin
        prev_live_q <= armed_q;
      end
      if (frame_tick) begin
        armed_q <= arm_req;
      end
    end
  end
endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine
  import dma_slot_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_tick,
  input  logic [SLOT_W-1:0] slot_in,
  input  logic [LANES-1:0]  mask_in,
  input  logic              ack_n,
  input  logic              take,
  output logic              req_n,
  output logic              beat_act,
  output logic [LANE_W-1:0] beat_lane,
  output logic [SLOT_W-1:0] beat_slot,
  output logic              miss
);
  eng_state_e        state_q;
  logic [LANES-1:0]  rem_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LANES-1:0]  sel;
  logic [LANES-1:0]  rem_after;
  logic              moved;

  // lowest pending lane goes first
  always_comb begin
    sel       = '0;
    beat_lane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (rem_q[i]) begin
        sel       = '0;
        sel[i]    = 1'b1;
        beat_lane = LANE_W'(i);
      end
    end
  end

  assign beat_act  = (state_q == ENG_BURST);
  assign req_n     = (state_q == ENG_IDLE);
  assign beat_slot = slot_q;
  assign moved     = beat_act && take;
  assign rem_after = moved ? (rem_q & ~sel) : rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      rem_q   <= '0;
      slot_q  <= '0;
      miss    <= 1'b0;
    end else if (slot_tick) begin
      miss    <= (state_q == ENG_WAIT) ||
                 ((state_q == ENG_BURST) && (rem_after != '0));
      rem_q   <= mask_in;
      slot_q  <= slot_in;
      state_q <= (mask_in != '0) ? ENG_WAIT : ENG_IDLE;
    end else begin
      miss <= 1'b0;
      case (state_q)
        ENG_WAIT: begin
          if (!ack_n) state_q <= ENG_BURST;
        end
        ENG_BURST: begin
          rem_q <= rem_after;
          if (rem_after == '0) state_q <= ENG_IDLE;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_wr_stagger.sv
module dma_wr_stagger
  import dma_slot_pkg::*;
#(
  parameter int CH_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [STRM_W-1:0] beat_stream,
  input  logic [CH_W-1:0]   beat_chan,
  input  logic [7:0]        beat_data,
  output logic              st_valid,
  output logic [STRM_W-1:0] st_stream,
  output logic [CH_W-1:0]   st_chan,
  output logic [7:0]        st_data
);
  logic [7:0]         park_data [STREAMS];
  logic [STREAMS-1:0] park_vld;

  for (genvar g = 0; g < STREAMS; g++) begin : g_park
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        park_vld[g]  <= 1'b0;
        park_data[g] <= '0;
      end else if (beat && (beat_stream == STRM_W'(g))) begin
        park_vld[g]  <= 1'b1;
        park_data[g] <= beat_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid  <= 1'b0;
      st_stream <= '0;
      st_chan   <= '0;
      st_data   <= '0;
    end else begin
      st_valid <= beat && park_vld[beat_stream];
      if (beat) begin
        st_stream <= beat_stream;
        st_chan   <= beat_chan;
        st_data   <= park_data[beat_stream];
      end
    end
  end
endmodule

// File: rtl/dma_slot_ctrl.sv
module dma_slot_ctrl
  import dma_slot_pkg::*;
#(
  parameter int SLOTS       = 32,
  parameter int SLOT_CYCLES = 16,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int CH_W       = SLOT_W + LANE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dma_en,
  input  logic [1:0]             mode,
  input  logic [SLOTS*LANES-1:0] chan_en,
  output logic                   rd_req_n,
  input  logic                   rd_ack_n,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [STRM_W-1:0]      rd_stream,
  output logic [CH_W-1:0]        rd_chan,
  output logic                   wr_req_n,
  input  logic                   wr_ack_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [7:0]             wr_data,
  output logic                   st_valid,
  output logic [STRM_W-1:0]      st_stream,
  output logic [CH_W-1:0]        st_chan,
  output logic [7:0]             st_data,
  output logic                   rd_miss,
  output logic                   wr_miss
);
  logic              slot_tick;
  logic [SLOT_W-1:0] cur_slot, prev_slot;
  logic              rd_live, wr_live;
  logic [LANES-1:0]  rd_mask, wr_mask;
  logic [LANE_W-1:0] rd_lane, wr_lane;
  logic [SLOT_W-1:0] rd_slot, wr_slot;
  logic [STRM_W-1:0] wr_stream;
  logic [CH_W-1:0]   wr_chan;
  slot_rate_e        rate;

  assign rate = slot_rate_e'(mode);

  function automatic logic [STRM_W-1:0] lane_stream(slot_rate_e r, logic [LANE_W-1:0] l);
    case (r)
      RATE_4M: lane_stream = {1'b0, l[1]};
      RATE_8M: lane_stream = '0;
      default: lane_stream = l;
    endcase
  endfunction

  function automatic logic [CH_W-1:0] lane_chan(slot_rate_e r, logic [SLOT_W-1:0] s,
                                               logic [LANE_W-1:0] l);
    case (r)
      RATE_4M: lane_chan = {1'b0, s, l[0]};
      RATE_8M: lane_chan = {s, l};
      default: lane_chan = {{LANE_W{1'b0}}, s};
    endcase
  endfunction

  dma_slot_timer #(.SLOTS(SLOTS), .SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_req   (dma_en),
    .slot_tick (slot_tick),
    .cur_slot  (cur_slot),
    .prev_slot (prev_slot),
    .rd_live   (rd_live),
    .wr_live   (wr_live)
  );

  assign rd_mask = rd_live ? chan_en[{cur_slot, {LANE_W{1'b0}}} +: LANES] : '0;
  assign wr_mask = wr_live ? chan_en[{prev_slot, {LANE_W{1'b0}}} +: LANES] : '0;

  dma_burst_engine #(.SLOT_W(SLOT_W)) u_rd_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_tick (slot_tick),
    .slot_in   (cur_slot),
    .mask_in   (rd_mask),
    .ack_n     (rd_ack_n),
    .take      (rd_ready),
    .req_n     (rd_req_n),
    .beat_act  (rd_valid),
    .beat_lane (rd_lane),
    .beat_slot (rd_slot),
    .miss      (rd_miss)
  );

  dma_burst_engine #(.SLOT_W(SLOT_W)) u_wr_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_tick (slot_tick),
    .slot_in   (prev_slot),
    .mask_in   (wr_mask),
    .ack_n     (wr_ack_n),
    .take      (wr_valid),
    .req_n     (wr_req_n),
    .beat_act  (wr_ready),
    .beat_lane (wr_lane),
    .beat_slot (wr_slot),
    .miss      (wr_miss)
  );

  assign rd_stream = lane_stream(rate, rd_lane);
  assign rd_chan   = lane_chan(rate, rd_slot, rd_lane);
  assign wr_stream = lane_stream(rate, wr_lane);
  assign wr_chan   = lane_chan(rate, wr_slot, wr_lane);

  dma_wr_stagger #(.CH_W(CH_W)) u_stagger (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat        (wr_valid && wr_ready),
    .beat_stream (wr_stream),
    .beat_chan   (wr_chan),
    .beat_data   (wr_data),
    .st_valid    (st_valid),
    .st_stream   (st_stream),
    .st_chan     (st_chan),
    .st_data     (st_data)
  );
endmodule

// File: rtl/dma_slot_chk.sv
module dma_slot_chk (
  input logic clk,
  input logic rst_n,
  input logic slot_tick,
  input logic rd_req_n,
  input logic rd_valid,
  input logic rd_ready,
  input logic wr_req_n,
  input logic wr_ready,
  input logic wr_valid,
  input logic st_valid,
  input logic rd_miss,
  input logic wr_miss
);
  p_rd_beat_in_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rd_req_n);

  p_wr_beat_in_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !wr_req_n);

  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !slot_tick) |=> rd_valid);

  p_rd_fall_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_req_n) |-> $past(slot_tick));

  p_wr_fall_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_req_n) |-> $past(slot_tick));

  p_rd_miss_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |-> ($past(!rd_req_n) && $past(slot_tick)));

  p_wr_miss_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_miss |-> ($past(!wr_req_n) && $past(slot_tick)));

  p_store_after_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(wr_valid && wr_ready));
endmodule

bind dma_slot_ctrl dma_slot_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_tick (slot_tick),
  .rd_req_n  (rd_req_n),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .wr_req_n  (wr_req_n),
  .wr_ready  (wr_ready),
  .wr_valid  (wr_valid),
  .st_valid  (st_valid),
  .rd_miss   (rd_miss),
  .wr_miss   (wr_miss)
);

// File: tb/tb_dma_slot_ctrl.sv
`timescale 1ns/1ps
module tb_dma_slot_ctrl;
  localparam int SLOTS = 32;
  localparam int SC    = 16;
  localparam int CH_W  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [SLOTS*4-1:0] en_cfg = '0;
  logic rd_req_n, rd_valid, wr_req_n, wr_ready, st_valid, rd_miss, wr_miss;
  logic rd_ack_n = 1'b1, rd_ready = 1'b0, wr_ack_n = 1'b1, wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_stream, st_stream;
  logic [CH_W-1:0] rd_chan, st_chan;
  logic [7:0] st_data;

  always #5 clk = ~clk;

  dma_slot_ctrl #(.SLOTS(SLOTS), .SLOT_CYCLES(SC)) dut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .mode(mode), .chan_en(en_cfg),
    .rd_req_n(rd_req_n), .rd_ack_n(rd_ack_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_stream(rd_stream), .rd_chan(rd_chan),
    .wr_req_n(wr_req_n), .wr_ack_n(wr_ack_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .st_valid(st_valid), .st_stream(st_stream), .st_chan(st_chan),
    .st_data(st_data), .rd_miss(rd_miss), .wr_miss(wr_miss)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int map_stream(int md, int l);
    if (md == 1) return l / 2;
    if (md == 2) return 0;
    return l;
  endfunction
  function automatic int map_chan(int md, int s, int l);
    if (md == 1) return s * 2 + (l % 2);
    if (md == 2) return s * 4 + l;
    return s;
  endfunction

  // ---------------- behavioural reference model ----------------
  int ecnt = 0;
  int m_cyc = 0, m_slot = 0;
  bit m_armed = 0, m_prev_live = 0;
  int rd_st = 0, wr_st = 0, rd_slot = 0, wr_slot = 0;
  int rq[$], wq[$];
  bit m_rd_miss = 0, m_wr_miss = 0;
  bit m_st_v = 0;
  int m_st_s = 0, m_st_c = 0, m_st_d = 0;
  int hd[4];
  bit hv[4];
  int n_rd_beats = 0, n_st = 0, n_wr_miss_seen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ecnt = 0; m_cyc = 0; m_slot = 0; m_armed = 0; m_prev_live = 0;
      rd_st = 0; wr_st = 0; rq.delete(); wq.delete();
      m_rd_miss = 0; m_wr_miss = 0; m_st_v = 0;
      for (int i = 0; i < 4; i++) begin hv[i] = 0; hd[i] = 0; end
    end else begin
      automatic bit tick = (m_cyc == 0);
      automatic int ps = (m_slot == 0) ? SLOTS - 1 : m_slot - 1;
      // staggered store (R8)
      m_st_v = 0;
      if (wr_st == 2 && wr_valid) begin
        automatic int k = map_stream(mode, wq[0]);
        m_st_v = hv[k]; m_st_s = k; m_st_c = map_chan(mode, wr_slot, wq[0]); m_st_d = hd[k];
        hd[k] = wr_data; hv[k] = 1;
        if (m_st_v) n_st++;
      end
      // read side
      if (rd_st == 2 && rd_ready) begin void'(rq.pop_front()); n_rd_beats++; end
      if (tick) begin
        m_rd_miss = (rd_st == 1) || (rd_st == 2 && rq.size() != 0);
        rq.delete(); rd_slot = m_slot;
        if (m_armed) for (int l = 0; l < 4; l++) if (en_cfg[m_slot*4+l]) rq.push_back(l);
        rd_st = (rq.size() != 0) ? 1 : 0;
      end else begin
        m_rd_miss = 0;
        if (rd_st == 1 && !rd_ack_n) rd_st = 2;
        else if (rd_st == 2 && rq.size() == 0) rd_st = 0;
      end
      // write side
      if (wr_st == 2 && wr_valid) void'(wq.pop_front());
      if (tick) begin
        m_wr_miss = (wr_st == 1) || (wr_st == 2 && wq.size() != 0);
        if (m_wr_miss) n_wr_miss_seen++;
        wq.delete(); wr_slot = ps;
        if (m_prev_live) for (int l = 0; l < 4; l++) if (en_cfg[ps*4+l]) wq.push_back(l);
        wr_st = (wq.size() != 0) ? 1 : 0;
      end else begin
        m_wr_miss = 0;
        if (wr_st == 1 && !wr_ack_n) wr_st = 2;
        else if (wr_st == 2 && wq.size() == 0) wr_st = 0;
      end
      // timing (R1, R2, R10)
      if (tick) m_prev_live = m_armed;
      if (tick && m_slot == 0) m_armed = dma_en;
      m_cyc = m_cyc + 1;
      if (m_cyc == SC) begin m_cyc = 0; m_slot = (m_slot + 1) % SLOTS; end
      ecnt++;
    end
  end

  // ---------------- compare and drive, away from the edge ----------------
  bit hold_rd = 0, hold_wr = 0, rnd = 0;
  logic [15:0] lfsr = 16'hACE1;
  int first_fall = -1;
  int early_lows = 0;
  int idle_lows = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(rd_req_n == (rd_st == 0), "R3", "rd_req_n", rd_req_n, rd_st == 0);
        chk(wr_req_n == (wr_st == 0), "R4", "wr_req_n", wr_req_n, wr_st == 0);
        chk(rd_valid == (rd_st == 2), "R5", "rd_valid", rd_valid, rd_st == 2);
        if (rd_valid && rd_st == 2) begin
          chk(rd_stream == map_stream(mode, rq[0]), "R6", "rd_stream", rd_stream, map_stream(mode, rq[0]));
          chk(rd_chan == map_chan(mode, rd_slot, rq[0]), "R6", "rd_chan", rd_chan, map_chan(mode, rd_slot, rq[0]));
        end
        chk(wr_ready == (wr_st == 2), "R7", "wr_ready", wr_ready, wr_st == 2);
        chk(st_valid == m_st_v, "R8", "st_valid", st_valid, m_st_v);
        if (st_valid && m_st_v) begin
          chk(st_stream == m_st_s, "R8", "st_stream", st_stream, m_st_s);
          chk(st_chan == m_st_c, "R8", "st_chan", st_chan, m_st_c);
          chk(st_data == m_st_d, "R8", "st_data", st_data, m_st_d);
        end
        chk(rd_miss == m_rd_miss, "R9", "rd_miss", rd_miss, m_rd_miss);
        chk(wr_miss == m_wr_miss, "R9", "wr_miss", wr_miss, m_wr_miss);
        if (!rd_req_n && first_fall < 0) first_fall = ecnt;
        if (ecnt >= 1025 && ecnt <= 1040 && !rd_req_n) early_lows++;
        if (ecnt >= 5200 && (!rd_req_n || !wr_req_n)) idle_lows++;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_ack_n = !(!rd_req_n && !hold_rd && (!rnd || lfsr[0]));
      wr_ack_n = !(!wr_req_n && !hold_wr && (!rnd || lfsr[3]));
      rd_ready = rnd ? lfsr[1] : 1'b1;
      wr_valid = rnd ? lfsr[2] : 1'b1;
      wr_data  = lfsr[15:8];
    end
  end

  task automatic wait_to(input int n);
    while (ecnt < n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", ecnt, 6000);
    finish_run();
  end

  initial begin
    en_cfg[0*4+0] = 1; en_cfg[0*4+2] = 1;
    en_cfg[1*4+1] = 1;
    en_cfg[3*4 +: 4] = 4'hF;
    en_cfg[7*4+3] = 1;
    en_cfg[12*4 +: 4] = 4'b0110;
    en_cfg[31*4+0] = 1; en_cfg[31*4+1] = 1;
    repeat (4) @(negedge clk);
    // R2: reset state
    chk(rd_req_n == 1 && wr_req_n == 1, "R2", "requests in reset", {rd_req_n, wr_req_n}, 3);
    chk(!rd_valid && !wr_ready && !st_valid && !rd_miss && !wr_miss, "R2", "outputs in reset",
        {rd_valid, wr_ready, st_valid, rd_miss, wr_miss}, 0);
    rst_n = 1'b1;
    // disarmed, then arm mid-frame 1 (pattern: 2 Mb/s, instant handshakes)
    wait_to(600);
    dma_en = 1'b1;
    wait_to(1100);
    chk(first_fall == 1041, "R1", "first read request edge", first_fall, 1041);
    chk(early_lows == 0, "R10", "slot 0 request in arming frame", early_lows, 0);
    wait_to(1537);
    chk(rd_req_n == 1'b0, "R10", "slot 0 read request next frame", rd_req_n, 0);
    // 4 Mb/s mapping with random back-pressure
    wait_to(2150);
    mode = 2'd1; rnd = 1'b1;
    // 8 Mb/s mapping, write acknowledges withheld
    wait_to(3100);
    mode = 2'd2;
    wait_to(3300);
    hold_wr = 1'b1;
    wait_to(3900);
    hold_wr = 1'b0;
    wait_to(4200);
    dma_en = 1'b0;
    wait_to(5700);
    chk(n_wr_miss_seen > 0, "R9", "write misses while acks withheld", n_wr_miss_seen, 1);
    chk(n_st > 0, "R8", "staggered stores seen", n_st, 1);
    chk(n_rd_beats > 0, "R5", "read beats moved", n_rd_beats, 1);
    chk(idle_lows == 0, "R2", "requests after disarm", idle_lows, 0);
    finish_run();
  end
endmodule